// File: doc/BRIEF.md
# GPIO Port Register Bank

This block is the software-visible register file of a 32-pin general-purpose I/O port. It holds the output data word, the per-pin direction, two words of interrupt sensitivity (two bits per pin, split into a low and a high half), the interrupt mask and an optional edge-override word. It drives the output pins and their enables, and it returns read data for every register.

Configuration words go out on plain wires to an interrupt detector, which is a separate block. That detector also returns the current status word, which this block serves on reads. A write to the status offset does not store anything here. It becomes a one-cycle clear strobe that carries the written bits. Pad levels arrive already synchronised on `pad_level`.

Accesses come in on a simple valid/write/address/data bus with byte enables. The bank takes one access per cycle and never back-pressures, so it has no ready signal. A read request is answered with `bus_rvalid` exactly one cycle later. There is no flow control on that answer, and the requester must accept it.

Top module: `gpio_regbank`

## Requirements
- R1: After reset the data, direction, sensitivity, mask and edge-override words are all 0. `pin_oe` and `pin_out` are 0, `bus_rvalid` and `stat_clr_pulse` are low, and every pin is an input.
- R2: A read request (`bus_valid`=1, `bus_write`=0) gives `bus_rvalid`=1 with the read word on `bus_rdata` in the next cycle. Without a request, `bus_rvalid` is 0 and `bus_rdata` is 0.
- R3: A read of the data word at offset 0x00 returns, bit by bit, the stored data bit where direction is 1 (output) and the `pad_level` bit where direction is 0 (input).
- R4: A read of pad status at 0x08 returns `pad_level` on input pins and 0 on output pins. Writes to 0x08 change no register.
- R5: `pin_oe` equals the direction word. `pin_out` equals the data word ANDed with the direction word.
- R6: Direction at 0x04, sensitivity low at 0x0C, sensitivity high at 0x10 and mask at 0x14 take the written word and read it back. They appear on their `cfg_*` outputs in the cycle after the write.
- R7: A full write to the status offset 0x18 raises `stat_clr_pulse` for exactly one cycle, the cycle after the write, with `stat_clr_bits` equal to the written word. A read of 0x18 returns `stat_value`.
- R8: With `HAS_EDGE`=1, the edge-override word at 0x1C is writable and readable and drives `cfg_edge`. With `HAS_EDGE`=0 it reads 0, `cfg_edge` stays 0, and writes to it are ignored.
- R9: An access with `bus_be` other than 4'hF is not full-width. As a write it changes nothing and gives no strobe. As a read it returns 0 with `bus_rvalid`=1.
- R10: An address with bits [1:0] nonzero, or at 0x20 or above, reads 0 and changes nothing when written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the access |
| bus_be | input | 4 | Byte enables; only 4'hF is accepted |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read answer, one cycle after request |
| pad_level | input | 32 | Synchronised pad levels |
| stat_value | input | 32 | Status word from the interrupt detector |
| pin_out | output | 32 | Output pin levels |
| pin_oe | output | 32 | Output pin enables (direction) |
| cfg_sense_lo | output | 32 | Sensitivity, pins 0 to 15 |
| cfg_sense_hi | output | 32 | Sensitivity, pins 16 to 31 |
| cfg_mask | output | 32 | Interrupt mask |
| cfg_edge | output | 32 | Edge-override word |
| stat_clr_pulse | output | 1 | One-cycle status clear strobe |
| stat_clr_bits | output | 32 | Bits to clear, valid with the strobe |

## Verification
Some checks run on every cycle. The read answer always follows a request by exactly one cycle. No pin drives a level while its enable is low. The clear strobe only follows a full write to the status offset. A partial write never disturbs the direction word. A pad-status answer never shows a bit of a pin that was an output, and a build without the override keeps `cfg_edge` at 0. Other behaviour only shows up in the bench's scenarios: the bitwise data mix, the read-back of each word and rejection of undefined or misaligned offsets. The bench runs a second instance without the override register to cover R8.

// File: rtl/gpio_regbank_pkg.sv
package gpio_regbank_pkg;
  localparam int NUM_REGS = 8;
  localparam int SEL_W    = $clog2(NUM_REGS);

  typedef enum logic [SEL_W-1:0] {
    SEL_DATA  = 3'd0,
    SEL_DIR   = 3'd1,
    SEL_PAD   = 3'd2,
    SEL_SNSLO = 3'd3,
    SEL_SNSHI = 3'd4,
    SEL_MASK  = 3'd5,
    SEL_STAT  = 3'd6,
    SEL_EDGE  = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/gpio_rb_decode.sv
module gpio_rb_decode
  import gpio_regbank_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BE_W   = 4
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BE_W-1:0]   req_be,
  output logic [NUM_REGS-1:0] wr_en,
  output logic              rd_req,
  output logic              rd_ok,
  output reg_sel_e          sel
);
  localparam int LSB = $clog2(BE_W);
  localparam int MAP_TOP = LSB + SEL_W;

  logic full_word, in_map;

  always_comb begin
    full_word = (req_be == {BE_W{1'b1}});
    in_map    = (req_addr[LSB-1:0] == '0) && (req_addr[ADDR_W-1:MAP_TOP] == '0);
    sel       = reg_sel_e'(req_addr[MAP_TOP-1:LSB]);
    rd_req    = req_valid && !req_write;
    rd_ok     = full_word && in_map;
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_wr
    assign wr_en[g] = req_valid && req_write && full_word && in_map && (sel == reg_sel_e'(g));
  end
endmodule

// File: rtl/gpio_rb_store.sv
module gpio_rb_store
  import gpio_regbank_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter bit HAS_EDGE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_REGS-1:0] wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q_data,
  output logic [DATA_W-1:0] q_dir,
  output logic [DATA_W-1:0] q_snslo,
  output logic [DATA_W-1:0] q_snshi,
  output logic [DATA_W-1:0] q_mask,
  output logic [DATA_W-1:0] q_edge,
  output logic              clr_pulse,
  output logic [DATA_W-1:0] clr_bits
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_data    <= '0;
      q_dir     <= '0;
      q_snslo   <= '0;
      q_snshi   <= '0;
      q_mask    <= '0;
      clr_pulse <= 1'b0;
      clr_bits  <= '0;
    end else begin
      if (wr_en[SEL_DATA])  q_data  <= wdata;
      if (wr_en[SEL_DIR])   q_dir   <= wdata;
      if (wr_en[SEL_SNSLO]) q_snslo <= wdata;
      if (wr_en[SEL_SNSHI]) q_snshi <= wdata;
      if (wr_en[SEL_MASK])  q_mask  <= wdata;
      clr_pulse <= wr_en[SEL_STAT];
      clr_bits  <= wr_en[SEL_STAT] ? wdata : '0;
    end
  end

  if (HAS_EDGE) begin : g_edge
    always_ff @(posedge clk) begin
      if (!rst_n)              q_edge <= '0;
      else if (wr_en[SEL_EDGE]) q_edge <= wdata;
    end
  end else begin : g_no_edge
    assign q_edge = '0;
  end

  // R6
  dir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en[SEL_DIR] |=> (q_dir == $past(wdata)));
endmodule

// File: rtl/gpio_rb_readmux.sv
module gpio_rb_readmux
  import gpio_regbank_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic              rd_ok,
  input  reg_sel_e          sel,
  input  logic [DATA_W-1:0] q_data,
  input  logic [DATA_W-1:0] q_dir,
  input  logic [DATA_W-1:0] q_snslo,
  input  logic [DATA_W-1:0] q_snshi,
  input  logic [DATA_W-1:0] q_mask,
  input  logic [DATA_W-1:0] q_edge,
  input  logic [DATA_W-1:0] pad,
  input  logic [DATA_W-1:0] stat,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  logic [DATA_W-1:0] word;

  always_comb begin
    unique case (sel)
      SEL_DATA:  word = (q_data & q_dir) | (pad & ~q_dir);
      SEL_DIR:   word = q_dir;
      SEL_PAD:   word = pad & ~q_dir;
      SEL_SNSLO: word = q_snslo;
      SEL_SNSHI: word = q_snshi;
      SEL_MASK:  word = q_mask;
      SEL_STAT:  word = stat;
      SEL_EDGE:  word = q_edge;
      default:   word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= rd_req;
      rdata  <= (rd_req && rd_ok) ? word : '0;
    end
  end

  // R2
  rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rvalid |-> (rdata == '0));
endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
  import gpio_regbank_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8,
  parameter bit HAS_EDGE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W/8-1:0] bus_be,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  input  logic [DATA_W-1:0] pad_level,
  input  logic [DATA_W-1:0] stat_value,
  output logic [DATA_W-1:0] pin_out,
  output logic [DATA_W-1:0] pin_oe,
  output logic [DATA_W-1:0] cfg_sense_lo,
  output logic [DATA_W-1:0] cfg_sense_hi,
  output logic [DATA_W-1:0] cfg_mask,
  output logic [DATA_W-1:0] cfg_edge,
  output logic              stat_clr_pulse,
  output logic [DATA_W-1:0] stat_clr_bits
);
  localparam int BE_W = DATA_W / 8;

  logic [NUM_REGS-1:0] wr_en;
  logic                rd_req, rd_ok;
  reg_sel_e            sel;
  logic [DATA_W-1:0]   q_data, q_dir;

  gpio_rb_decode #(.ADDR_W(ADDR_W), .BE_W(BE_W)) u_dec (
    .req_valid(bus_valid), .req_write(bus_write), .req_addr(bus_addr),
    .req_be(bus_be), .wr_en(wr_en), .rd_req(rd_req), .rd_ok(rd_ok), .sel(sel)
  );

  gpio_rb_store #(.DATA_W(DATA_W), .HAS_EDGE(HAS_EDGE)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(bus_wdata),
    .q_data(q_data), .q_dir(q_dir), .q_snslo(cfg_sense_lo),
    .q_snshi(cfg_sense_hi), .q_mask(cfg_mask), .q_edge(cfg_edge),
    .clr_pulse(stat_clr_pulse), .clr_bits(stat_clr_bits)
  );

  gpio_rb_readmux #(.DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_ok(rd_ok), .sel(sel),
    .q_data(q_data), .q_dir(q_dir), .q_snslo(cfg_sense_lo),
    .q_snshi(cfg_sense_hi), .q_mask(cfg_mask), .q_edge(cfg_edge),
    .pad(pad_level), .stat(stat_value), .rdata(bus_rdata), .rvalid(bus_rvalid)
  );

  assign pin_oe  = q_dir;
  assign pin_out = q_data & q_dir;

  // R2
  rd_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |=> bus_rvalid);
  // R2
  rd_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid |-> $past(bus_valid && !bus_write));
  // R5
  pin_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~pin_oe) == '0);
  // R7
  clr_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_clr_pulse |-> $past(bus_valid && bus_write && bus_be == {BE_W{1'b1}}
                             && bus_addr == ADDR_W'(8'h18)));
  // R9
  partial_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_valid && bus_write && bus_be != {BE_W{1'b1}}) |-> $stable(pin_oe));
  // R4
  pad_hide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && bus_addr == ADDR_W'(8'h08)) |=>
      ((bus_rdata & $past(pin_oe)) == '0));
  // R8
  edge_absent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !HAS_EDGE |-> (cfg_edge == '0));
endmodule

// File: tb/gpio_regbank_tb_top.sv
module gpio_regbank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0, pad_level = '0, stat_value = '0;
  logic [31:0] bus_rdata, pin_out, pin_oe, cfg_sense_lo, cfg_sense_hi, cfg_mask, cfg_edge, stat_clr_bits;
  logic        bus_rvalid, stat_clr_pulse;
  logic [31:0] ne_rdata, ne_pin_out, ne_pin_oe, ne_lo, ne_hi, ne_mask, ne_edge, ne_clr_bits;
  logic        ne_rvalid, ne_clr_pulse;

  always #2 clk = ~clk;

  gpio_regbank dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .pad_level(pad_level),
    .stat_value(stat_value), .pin_out(pin_out), .pin_oe(pin_oe),
    .cfg_sense_lo(cfg_sense_lo), .cfg_sense_hi(cfg_sense_hi), .cfg_mask(cfg_mask),
    .cfg_edge(cfg_edge), .stat_clr_pulse(stat_clr_pulse), .stat_clr_bits(stat_clr_bits)
  );

  gpio_regbank #(.HAS_EDGE(1'b0)) dut_ne (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(ne_rdata), .bus_rvalid(ne_rvalid), .pad_level(pad_level),
    .stat_value(stat_value), .pin_out(ne_pin_out), .pin_oe(ne_pin_oe),
    .cfg_sense_lo(ne_lo), .cfg_sense_hi(ne_hi), .cfg_mask(ne_mask),
    .cfg_edge(ne_edge), .stat_clr_pulse(ne_clr_pulse), .stat_clr_bits(ne_clr_bits)
  );

  int errors = 0, checks = 0;
  logic [31:0] m_data = 0, m_dir = 0, m_lo = 0, m_hi = 0, m_mask = 0, m_edge = 0;
  logic [63:0] sb_q[$];
  bit done = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_rd(logic [7:0] a, logic [3:0] be, bit edge_on);
    if (be != 4'hF || a[1:0] != 0 || a >= 8'h20) return 32'h0; // R9 R10
    case (a[4:2])
      3'd0: return (m_data & m_dir) | (pad_level & ~m_dir);
      3'd1: return m_dir;
      3'd2: return pad_level & ~m_dir;
      3'd3: return m_lo;
      3'd4: return m_hi;
      3'd5: return m_mask;
      3'd6: return stat_value;
      default: return edge_on ? m_edge : 32'h0;
    endcase
  endfunction

  task automatic bus_rd(logic [7:0] a, logic [3:0] be = 4'hF);
    @(negedge clk);
    sb_q.push_back({model_rd(a, be, 1'b1), model_rd(a, be, 1'b0)});
    bus_valid = 1; bus_write = 0; bus_addr = a; bus_be = be;
    @(negedge clk);
    bus_valid = 0;
  endtask

  task automatic bus_wr(logic [7:0] a, logic [31:0] d, logic [3:0] be = 4'hF);
    bit ok;
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0;
    ok = (be == 4'hF) && (a[1:0] == 0) && (a < 8'h20);
    if (ok) case (a[4:2])
      3'd0: m_data = d;
      3'd1: m_dir = d;
      3'd3: m_lo = d;
      3'd4: m_hi = d;
      3'd5: m_mask = d;
      3'd7: m_edge = d;
      default: ;
    endcase
    // R7 strobe in the cycle after the write, carrying the word
    chk("R7 pulse", {31'b0, stat_clr_pulse}, {31'b0, ok && a == 8'h18});
    chk("R7 bits", stat_clr_bits, (ok && a == 8'h18) ? d : 32'h0);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      #1;
      if (bus_rvalid) begin
        if (sb_q.size() == 0) chk("R2 unexpected rvalid", 32'h1, 32'h0);
        else begin
          logic [63:0] e;
          e = sb_q.pop_front();
          chk("R2 R3 R4 R6 read", bus_rdata, e[63:32]);
          chk("R8 no-edge read", ne_rdata, e[31:0]);
        end
      end else chk("R2 idle rdata", bus_rdata, 32'h0);
    end
  end

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    pad_level = 32'hA5A5_3C3C; stat_value = 32'h0000_F00D;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 pin_oe", pin_oe, 0); chk("R1 pin_out", pin_out, 0);
    chk("R1 mask", cfg_mask, 0); chk("R1 edge", cfg_edge, 0);
    chk("R1 rvalid", {31'b0, bus_rvalid}, 0);
    bus_rd(8'h00); bus_rd(8'h04);
    // R6 config words
    bus_wr(8'h04, 32'hFFFF_0000);
    chk("R6 cfg dir", pin_oe, 32'hFFFF_0000);
    bus_wr(8'h0C, 32'h1234_5678); chk("R6 lo", cfg_sense_lo, 32'h1234_5678);
    bus_wr(8'h10, 32'h9ABC_DEF0); chk("R6 hi", cfg_sense_hi, 32'h9ABC_DEF0);
    bus_wr(8'h14, 32'h0F0F_0F0F); chk("R6 mask", cfg_mask, 32'h0F0F_0F0F);
    bus_rd(8'h04); bus_rd(8'h0C); bus_rd(8'h10); bus_rd(8'h14);
    // R3 R5 data mix and pins
    bus_wr(8'h00, 32'h5A5A_5A5A);
    chk("R5 pin_out", pin_out, 32'h5A5A_0000);
    bus_rd(8'h00);
    pad_level = 32'h0000_FFFF; bus_rd(8'h00);
    bus_wr(8'h04, 32'h00FF_00FF);
    chk("R5 pin_out dir change", pin_out, 32'h005A_005A);
    bus_rd(8'h00); bus_rd(8'h08);
    // R4 pad status not writable
    bus_wr(8'h08, 32'hFFFF_FFFF); bus_rd(8'h08); bus_rd(8'h04);
    // R7 status
    bus_wr(8'h18, 32'h0000_00C3); bus_rd(8'h18);
    // R8 edge override
    bus_wr(8'h1C, 32'hDEAD_BEEF);
    chk("R8 cfg_edge", cfg_edge, 32'hDEAD_BEEF);
    chk("R8 ne cfg_edge", ne_edge, 32'h0);
    bus_rd(8'h1C);
    // R9 partial accesses
    bus_wr(8'h04, 32'h1111_1111, 4'h3); chk("R9 dir kept", pin_oe, 32'h00FF_00FF);
    bus_wr(8'h18, 32'h1, 4'h7);
    bus_rd(8'h04, 4'h1);
    // R10 undefined and misaligned
    bus_wr(8'h20, 32'hFFFF_FFFF); bus_wr(8'h06, 32'hFFFF_FFFF);
    chk("R10 dir kept", pin_oe, 32'h00FF_00FF);
    bus_rd(8'h20); bus_rd(8'h06); bus_rd(8'hFC); bus_rd(8'h04);
    // back-to-back reads
    @(negedge clk);
    sb_q.push_back({model_rd(8'h14, 4'hF, 1), model_rd(8'h14, 4'hF, 0)});
    bus_valid = 1; bus_write = 0; bus_addr = 8'h14; bus_be = 4'hF;
    @(negedge clk);
    sb_q.push_back({model_rd(8'h0C, 4'hF, 1), model_rd(8'h0C, 4'hF, 0)});
    bus_addr = 8'h0C;
    @(negedge clk);
    bus_valid = 0;
    repeat (3) @(negedge clk);
    chk("R2 queue drained", sb_q.size(), 0);
    finish_run();
  end
endmodule